// File: doc/BRIEF.md
# Debug Mailbox Channel

This block is a two-way, one-word mailbox between a processor and an external debugger. An outbound register carries words from the processor to the debugger. An inbound register carries words from the debugger to the processor. Each direction has a handshake flag. The W flag is set when the processor deposits an outbound word, and it is cleared when the debugger collects that word. The R flag is set when the debugger deposits an inbound word, and it is cleared when the processor takes it. Each side changes the flags only as a side effect of accessing a data register.

The processor side sees a control word made from the two flags, the inbound word, and a write strobe for the outbound word. The debugger side has single-cycle strobes that stand in for scan accesses. A debugger read of the outbound register captures the stored word together with a valid bit taken from W at that moment. The valid bit is placed at bit 0 of an accompanying address field, so the debugger can read without polling first. If a word is written into a direction whose flag is still set, the word is dropped and a sticky overrun bit for that direction is raised. Both sides share one clock.

Top module: `dbg_mailbox`

## Requirements
- R1: After reset, both flags, both data registers, the captured word, the captured valid bit and both overrun bits are zero.
- R2: A processor outbound write with W clear stores the word, and W reads as 1 from the next cycle.
- R3: A debugger outbound read registers the outbound word on `dbg_cap_data` and W on bit 0 of `dbg_cap_addr`; the upper address bits are 0. Both are visible the cycle after the strobe. The read clears W unless a write is accepted in the same cycle.
- R4: A debugger outbound read while W is clear returns valid = 0 and the stale word, and W stays 0.
- R5: A debugger inbound write with R clear stores the word, R reads as 1 from the next cycle, and `cpu_in_rdata` shows the stored word.
- R6: A processor inbound read clears R from the next cycle, unless a debugger write is accepted in the same cycle.
- R7: `cpu_ctrl` bit 0 is R, bit 1 is W, and all other bits are 0. `dbg_status` is {W, R}.
- R8: A processor outbound write while W is set, with no debugger read in the same cycle, is discarded. The outbound word and W are unchanged, and `out_overrun` becomes 1.
- R9: A debugger inbound write while R is set, with no processor read in the same cycle, is discarded. The inbound word and R are unchanged, and `in_overrun` becomes 1.
- R10: If a flag is set and cleared in the same cycle, the flag ends set, the new word is stored and no overrun is raised. A debugger read in that cycle captures the old outbound word with valid = 1.
- R11: Once set, an overrun bit stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_out_wr | input | 1 | Processor write strobe for the outbound word |
| cpu_out_wdata | input | DATA_W | Outbound word from the processor |
| cpu_in_rd | input | 1 | Processor read strobe for the inbound word; clears R |
| cpu_in_rdata | output | DATA_W | Current inbound word |
| cpu_ctrl | output | DATA_W | Control word: bit 0 R, bit 1 W |
| dbg_out_rd | input | 1 | Debugger read strobe for the outbound word; clears W |
| dbg_cap_data | output | DATA_W | Word captured by the last debugger read |
| dbg_cap_addr | output | ADDR_W | Address field of the capture; bit 0 is the valid bit |
| dbg_in_wr | input | 1 | Debugger write strobe for the inbound word |
| dbg_in_wdata | input | DATA_W | Inbound word from the debugger |
| dbg_status | output | 2 | {W, R} as seen by the debugger |
| out_overrun | output | 1 | Sticky: an outbound write was dropped |
| in_overrun | output | 1 | Sticky: an inbound write was dropped |

## Verification
The hardest case to reach is the same-cycle collision: a write and the clearing access land on the same flag in one edge while that flag is already set. In normal polled use this never happens, because each side waits on the other. The directed part of the bench first sets a flag, then fires both strobes together, for both directions. It then checks the stored word, the flag, the captured old word, and that no overrun was raised. The random phase draws each strobe independently on every cycle, so collisions, discarded writes and stale captures also occur in varied orders.

// File: rtl/dbg_mailbox.sv
module dbg_mailbox #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_out_wr,
  input  logic [DATA_W-1:0] cpu_out_wdata,
  input  logic              cpu_in_rd,
  output logic [DATA_W-1:0] cpu_in_rdata,
  output logic [DATA_W-1:0] cpu_ctrl,
  input  logic              dbg_out_rd,
  output logic [DATA_W-1:0] dbg_cap_data,
  output logic [ADDR_W-1:0] dbg_cap_addr,
  input  logic              dbg_in_wr,
  input  logic [DATA_W-1:0] dbg_in_wdata,
  output logic [1:0]        dbg_status,
  output logic              out_overrun,
  output logic              in_overrun
);

  logic              w_q, r_q, cap_valid_q;
  logic [DATA_W-1:0] out_q, in_q, cap_q;
  logic              acc_out, acc_in;

  // A write is taken when the slot is free or being emptied this cycle
  assign acc_out = cpu_out_wr && (!w_q || dbg_out_rd);
  assign acc_in  = dbg_in_wr  && (!r_q || cpu_in_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q         <= 1'b0;
      r_q         <= 1'b0;
      out_q       <= '0;
      in_q        <= '0;
      cap_q       <= '0;
      cap_valid_q <= 1'b0;
      out_overrun <= 1'b0;
      in_overrun  <= 1'b0;
    end else begin
      if (dbg_out_rd) begin
        cap_q       <= out_q;
        cap_valid_q <= w_q;
      end
      if (acc_out)         out_q <= cpu_out_wdata;
      if (acc_out)         w_q   <= 1'b1;
      else if (dbg_out_rd) w_q   <= 1'b0;
      if (cpu_out_wr && !acc_out) out_overrun <= 1'b1;

      if (acc_in)          in_q  <= dbg_in_wdata;
      if (acc_in)          r_q   <= 1'b1;
      else if (cpu_in_rd)  r_q   <= 1'b0;
      if (dbg_in_wr && !acc_in) in_overrun <= 1'b1;
    end
  end

  assign cpu_in_rdata = in_q;
  assign cpu_ctrl     = {{(DATA_W-2){1'b0}}, w_q, r_q};
  assign dbg_status   = {w_q, r_q};
  assign dbg_cap_data = cap_q;
  assign dbg_cap_addr = {{(ADDR_W-1){1'b0}}, cap_valid_q};

  AST_W_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_out_wr && !dbg_status[1] |=> dbg_status[1]); // R2
  AST_W_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_out_rd && !cpu_out_wr |=> !dbg_status[1]); // R3
  AST_CAP_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_out_rd |=> dbg_cap_addr[0] == $past(dbg_status[1])); // R4
  AST_R_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_in_wr && !dbg_status[0] |=> dbg_status[0] && cpu_in_rdata == $past(dbg_in_wdata)); // R5
  AST_R_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_in_rd && !dbg_in_wr |=> !cpu_ctrl[0]); // R6
  AST_OUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_out_wr && dbg_status[1] && !dbg_out_rd |=> out_overrun && $stable(out_q)); // R8
  AST_IN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_in_wr && dbg_status[0] && !cpu_in_rd |=> in_overrun && $stable(cpu_in_rdata)); // R9
  AST_OUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    out_overrun |=> out_overrun); // R11
  AST_IN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    in_overrun |=> in_overrun); // R11

endmodule

// File: tb/dbg_mailbox_bench.sv
module dbg_mailbox_bench;
  localparam int DW = 32;
  localparam int AW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_out_wr = 0, cpu_in_rd = 0, dbg_out_rd = 0, dbg_in_wr = 0;
  logic [DW-1:0] cpu_out_wdata = '0, dbg_in_wdata = '0;
  logic [DW-1:0] cpu_in_rdata, cpu_ctrl, dbg_cap_data;
  logic [AW-1:0] dbg_cap_addr;
  logic [1:0]    dbg_status;
  logic          out_overrun, in_overrun;

  always #5 clk = ~clk;

  dbg_mailbox #(.DATA_W(DW), .ADDR_W(AW)) u_dbg_mailbox (
    .clk(clk), .rst_n(rst_n),
    .cpu_out_wr(cpu_out_wr), .cpu_out_wdata(cpu_out_wdata),
    .cpu_in_rd(cpu_in_rd), .cpu_in_rdata(cpu_in_rdata), .cpu_ctrl(cpu_ctrl),
    .dbg_out_rd(dbg_out_rd), .dbg_cap_data(dbg_cap_data), .dbg_cap_addr(dbg_cap_addr),
    .dbg_in_wr(dbg_in_wr), .dbg_in_wdata(dbg_in_wdata), .dbg_status(dbg_status),
    .out_overrun(out_overrun), .in_overrun(in_overrun));

  int checks = 0, fails = 0;
  bit done = 0;
  logic m_w, m_r, m_cv, m_oo, m_io;
  logic [DW-1:0] m_out, m_in, m_cd;

  function automatic logic [DW-1:0] exp_ctrl(logic r, logic w);
    return {{(DW-2){1'b0}}, w, r};
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic v);
    return {{(AW-1){1'b0}}, v};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7 ctrl", 64'(cpu_ctrl), 64'(exp_ctrl(m_r, m_w)));
    chk("R7 status", 64'(dbg_status), 64'({m_w, m_r}));
    chk("R5 inbound word", 64'(cpu_in_rdata), 64'(m_in));
    chk("R3 capture data", 64'(dbg_cap_data), 64'(m_cd));
    chk("R3 capture addr", 64'(dbg_cap_addr), 64'(exp_addr(m_cv)));
    chk("R8 out overrun", 64'(out_overrun), 64'(m_oo));
    chk("R9 in overrun", 64'(in_overrun), 64'(m_io));
  endtask

  task automatic step(logic cow, logic [DW-1:0] cod, logic cir,
                      logic dor, logic diw, logic [DW-1:0] did);
    logic ao, ai;
    cpu_out_wr = cow; cpu_out_wdata = cod; cpu_in_rd = cir;
    dbg_out_rd = dor; dbg_in_wr = diw; dbg_in_wdata = did;
    ao = cow && (!m_w || dor);
    ai = diw && (!m_r || cir);
    if (dor) begin m_cd = m_out; m_cv = m_w; end
    if (ao) m_out = cod;
    m_w = ao ? 1'b1 : (dor ? 1'b0 : m_w);
    if (cow && !ao) m_oo = 1'b1;
    if (ai) m_in = did;
    m_r = ai ? 1'b1 : (cir ? 1'b0 : m_r);
    if (diw && !ai) m_io = 1'b1;
    @(posedge clk); #1;
    cpu_out_wr = 0; cpu_in_rd = 0; dbg_out_rd = 0; dbg_in_wr = 0;
    check_all();
  endtask

  initial begin
    int unsigned seed;
    m_w = 0; m_r = 0; m_cv = 0; m_oo = 0; m_io = 0;
    m_out = '0; m_in = '0; m_cd = '0;
    seed = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 ctrl", 64'(cpu_ctrl), 64'd0);
    chk("R1 capture", 64'({dbg_cap_data, dbg_cap_addr}), 64'd0);
    chk("R1 overruns", 64'({out_overrun, in_overrun}), 64'd0);
    chk("R1 inbound", 64'(cpu_in_rdata), 64'd0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    // R2 write outbound, R3 collect with valid
    step(1, 32'hCAFE_0001, 0, 0, 0, '0);
    chk("R2 W set", 64'(cpu_ctrl[1]), 64'd1);
    step(0, '0, 0, 1, 0, '0);
    chk("R3 capture word", 64'(dbg_cap_data), 64'hCAFE_0001);
    chk("R3 valid bit", 64'(dbg_cap_addr), 64'd1);
    // R4 read with W clear
    step(0, '0, 0, 1, 0, '0);
    chk("R4 stale word", 64'(dbg_cap_data), 64'hCAFE_0001);
    chk("R4 valid zero", 64'({dbg_cap_addr, dbg_status[1]}), 64'd0);
    // R8 drop when W set, R11 sticky
    step(1, 32'h1111_2222, 0, 0, 0, '0);
    step(1, 32'h3333_4444, 0, 0, 0, '0);
    chk("R8 overrun", 64'(out_overrun), 64'd1);
    step(0, '0, 0, 1, 0, '0);
    chk("R8 kept word", 64'(dbg_cap_data), 64'h1111_2222);
    step(0, '0, 0, 0, 0, '0);
    chk("R11 out sticky", 64'(out_overrun), 64'd1);
    // R5 inbound, R6 clear
    step(0, '0, 0, 0, 1, 32'h5A5A_0F0F);
    chk("R5 R set", 64'(cpu_ctrl), 64'd1);
    chk("R5 word", 64'(cpu_in_rdata), 64'h5A5A_0F0F);
    step(0, '0, 1, 0, 0, '0);
    chk("R6 R clear", 64'(cpu_ctrl[0]), 64'd0);
    // R9 drop inbound
    step(0, '0, 0, 0, 1, 32'hAAAA_0001);
    step(0, '0, 0, 0, 1, 32'hBBBB_0002);
    chk("R9 kept word", 64'(cpu_in_rdata), 64'hAAAA_0001);
    chk("R9 overrun", 64'(in_overrun), 64'd1);
    // R10 collisions, both directions
    step(1, 32'h0000_00A1, 0, 0, 0, '0);
    step(1, 32'h0000_00A2, 0, 1, 0, '0);
    chk("R10 W stays set", 64'(dbg_status[1]), 64'd1);
    chk("R10 old captured", 64'({dbg_cap_data, dbg_cap_addr}), 64'({32'h0000_00A1, 5'd1}));
    step(0, '0, 1, 0, 1, 32'h0000_00B2);
    chk("R10 R stays set", 64'(dbg_status[0]), 64'd1);
    chk("R10 new inbound", 64'(cpu_in_rdata), 64'h0000_00B2);
    step(0, '0, 0, 1, 0, '0);
    chk("R10 new outbound", 64'(dbg_cap_data), 64'h0000_00A2);

    // Random phase
    for (int i = 0; i < 600; i++) begin
      step($urandom % 3 == 0, $urandom, $urandom % 3 == 0,
           $urandom % 3 == 0, $urandom % 3 == 0, $urandom);
    end

    // R1 reset again clears everything
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    chk("R1 re-reset", 64'({cpu_ctrl[1:0], out_overrun, in_overrun, dbg_cap_addr}), 64'd0);
    chk("R1 re-reset data", 64'(cpu_in_rdata), 64'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule